// File: doc/BRIEF.md
# Dual-Channel Integration Sequencer

This block sequences the integration periods of a two-photodiode light sensor. A front-end modulator emits one charge-balance pulse per unit of collected charge. The block tells that front end which diode to connect through `chan_sel_o`, and it counts the pulses that arrive while a window is open. When a window closes, it publishes a 16-bit result and the number of clock cycles the window lasted. Both values update in the same cycle as a one-cycle `done_o` strobe.

A two-bit mode code selects the conversion:

- Mode 0 reads the broadband diode (visible plus infrared).
- Mode 1 reads the mostly-infrared diode.
- Mode 3 runs a broadband window and then an infrared window, and reports their difference clamped at zero.
- Mode 2 is reserved and keeps the block idle.

A window can end in one of two ways. With internal timing, it ends after a power-of-two number of clocks chosen by `res_sel_i`. With external timing, it runs from one `sync_i` command to the next. As long as `enable_i` stays high, windows follow each other back to back. Each new window takes its configuration from the inputs at the moment it starts.

Top module: `integ_seq`

## Requirements
- R1: After reset `result_o`, `timer_o`, `done_o` and `integrating_o` are all zero.
- R2: In mode 0 (`mode_i`=0) every integrating cycle has `chan_sel_o`=0, and the result is the number of pulses seen in that window.
- R3: In mode 1 (`mode_i`=1) every integrating cycle has `chan_sel_o`=1, and the result is the number of pulses seen in that window.
- R4: In mode 3 (`mode_i`=3) a channel-0 window is followed at once by a channel-1 window. The result is count0 minus count1, and `timer_o` gives the length of the channel-1 window.
- R5: In mode 3, when count1 exceeds count0, the result is 0.
- R6: With internal timing (`ext_i`=0), each window lasts 2^(4*(k+1)) cycles, where k=`res_sel_i` (encodings 0..3 give 4, 8, 12 or 16 bits). `timer_o` reports that length, saturated.
- R7: With external timing (`ext_i`=1), a `sync_i` pulse in idle starts a window on the next cycle. The next `sync_i` closes the window, and that cycle is included in it. `timer_o` equals the number of cycles from one sync to the next, and the closing sync also opens the following window.
- R8: The pulse count and the cycle count each saturate at 0xFFFF instead of wrapping.
- R9: `done_o` is high for exactly the cycles in which `result_o` and `timer_o` hold freshly updated values. Without `done_o` both outputs hold their previous values.
- R10: Mode 2 is reserved. While it is applied, no window starts and no result is produced.
- R11: Dropping `enable_i` during a window aborts it on the next cycle, with no `done_o` and no change to the outputs.
- R12: While enabled, a new window begins in the same cycle that `done_o` is raised for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run conversions |
| mode_i | input | 2 | Conversion mode code |
| ext_i | input | 1 | 1 = window bounded by sync commands |
| res_sel_i | input | 2 | Internal window width select |
| sync_i | input | 1 | Sync command pulse |
| pulse_i | input | 1 | Charge-balance pulse from modulator |
| chan_sel_o | output | 1 | Diode select, 0 = broadband, 1 = infrared |
| integrating_o | output | 1 | Window open this cycle |
| result_o | output | 16 | Latest conversion result |
| timer_o | output | 16 | Cycle length of last window |
| done_o | output | 1 | One-cycle result update strobe |

## Verification
The bench uses the default parameters: a 16-bit counter width and 4-bit resolution steps. This brings every internal window length within reach, including the full 65536-cycle window. Running that window with the pulse input held high drives both counters into saturation. External spacings go down to a single cycle, which exercises back-to-back sync-bounded windows. Mode 3 runs with separate pulse densities per channel, so both the positive-difference case and the clamped case occur.

// File: rtl/integ_seq_pkg.sv
package integ_seq_pkg;
  typedef enum logic [1:0] {
    MODE_CH1  = 2'd0,
    MODE_CH2  = 2'd1,
    MODE_RSV  = 2'd2,
    MODE_DIFF = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic       ext;
    logic [1:0] res;
  } cfg_t;
endpackage

// File: rtl/integ_win_timer.sv
module integ_win_timer #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2,
  parameter int STEP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ext_i,
  input  logic [SEL_W-1:0] res_sel_i,
  input  logic             sync_i,
  output logic             phase_end_o,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] MAX = '1;
  localparam int N_SEL = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // terminal count per select; widths at or beyond CNT_W saturate
  always_comb begin
    lim = MAX;
    for (int k = 0; k < N_SEL; k++) begin
      if (res_sel_i == SEL_W'(k) && STEP * (k + 1) < CNT_W)
        lim = CNT_W'((64'd1 << (STEP * (k + 1))) - 64'd1);
    end
  end

  assign phase_end_o = run_i && (ext_i ? sync_i : (cnt_q == lim));
  assign len_o       = (cnt_q == MAX) ? MAX : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || phase_end_o) cnt_q <= '0;
    else if (cnt_q != MAX)         cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/integ_pulse_acc.sv
module integ_pulse_acc #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] now_o
);
  localparam logic [CNT_W-1:0] MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  // count including this cycle's pulse, saturating
  assign now_o = (run_i && pulse_i && cnt_q != MAX) ? cnt_q + CNT_W'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || clr_i) cnt_q <= '0;
    else                      cnt_q <= now_o;
  end
endmodule

// File: rtl/integ_seq_ctrl.sv
module integ_seq_ctrl
  import integ_seq_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [1:0]       mode_i,
  input  logic             ext_i,
  input  logic [SEL_W-1:0] res_sel_i,
  input  logic             sync_i,
  input  logic             phase_end_i,
  output logic             run_o,
  output logic             chan_o,
  output cfg_t             cfg_o,
  output logic             store_ch1_o,
  output logic             final_o
);
  logic busy_q, chan_q;
  cfg_t cfg_q, cfg_in;
  logic start_ok, closing;

  always_comb begin
    cfg_in.mode = mode_e'(mode_i);
    cfg_in.ext  = ext_i;
    cfg_in.res  = res_sel_i;
  end

  assign start_ok    = enable_i && (mode_i != MODE_RSV) && (!ext_i || sync_i);
  assign closing     = busy_q && enable_i && phase_end_i;
  assign store_ch1_o = closing && (cfg_q.mode == MODE_DIFF) && !chan_q;
  assign final_o     = closing && !store_ch1_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      chan_q <= 1'b0;
      cfg_q  <= '{mode: MODE_CH1, ext: 1'b0, res: '0};
    end else if (!busy_q) begin
      if (start_ok) begin
        busy_q <= 1'b1;
        cfg_q  <= cfg_in;
        chan_q <= (mode_i == MODE_CH2);
      end
    end else if (!enable_i) begin
      busy_q <= 1'b0;
    end else if (store_ch1_o) begin
      chan_q <= 1'b1;
    end else if (final_o) begin
      if (start_ok) begin
        cfg_q  <= cfg_in;
        chan_q <= (mode_i == MODE_CH2);
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign run_o  = busy_q;
  assign chan_o = chan_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/integ_result_reg.sv
module integ_result_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             store_ch1_i,
  input  logic             final_i,
  input  logic             diff_i,
  input  logic [CNT_W-1:0] acc_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] result_o,
  output logic [CNT_W-1:0] timer_o,
  output logic             done_o
);
  logic [CNT_W-1:0] ch1_q, diff_val;

  assign diff_val = (acc_i > ch1_q) ? '0 : ch1_q - acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch1_q    <= '0;
      result_o <= '0;
      timer_o  <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= final_i;
      if (store_ch1_i) ch1_q <= acc_i;
      if (final_i) begin
        result_o <= diff_i ? diff_val : acc_i;
        timer_o  <= len_i;
      end
    end
  end
endmodule

// File: rtl/integ_seq.sv
module integ_seq
  import integ_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2,
  parameter int STEP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [1:0]       mode_i,
  input  logic             ext_i,
  input  logic [SEL_W-1:0] res_sel_i,
  input  logic             sync_i,
  input  logic             pulse_i,
  output logic             chan_sel_o,
  output logic             integrating_o,
  output logic [CNT_W-1:0] result_o,
  output logic [CNT_W-1:0] timer_o,
  output logic             done_o
);
  logic             run, phase_end, store_ch1, final_s;
  cfg_t             cfg;
  logic [CNT_W-1:0] acc_now, len;

  integ_seq_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .mode_i, .ext_i, .res_sel_i, .sync_i,
    .phase_end_i(phase_end), .run_o(run), .chan_o(chan_sel_o), .cfg_o(cfg),
    .store_ch1_o(store_ch1), .final_o(final_s)
  );

  integ_win_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W), .STEP(STEP)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .ext_i(cfg.ext),
    .res_sel_i(SEL_W'(cfg.res)), .sync_i,
    .phase_end_o(phase_end), .len_o(len)
  );

  integ_pulse_acc #(.CNT_W(CNT_W)) u_acc (
    .clk_i, .rst_ni, .run_i(run), .clr_i(phase_end), .pulse_i, .now_o(acc_now)
  );

  integ_result_reg #(.CNT_W(CNT_W)) u_res (
    .clk_i, .rst_ni, .store_ch1_i(store_ch1), .final_i(final_s),
    .diff_i(cfg.mode == MODE_DIFF), .acc_i(acc_now), .len_i(len),
    .result_o, .timer_o, .done_o
  );

  assign integrating_o = run;
endmodule

// File: rtl/integ_seq_chk.sv
module integ_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic [1:0]       mode_i,
  input logic             chan_sel_o,
  input logic             integrating_o,
  input logic [CNT_W-1:0] result_o,
  input logic [CNT_W-1:0] timer_o,
  input logic             done_o,
  input logic [1:0]       cfg_mode_i
);
  AST_MODE0_CH1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integrating_o && cfg_mode_i == 2'd0) |-> !chan_sel_o); // R2
  AST_MODE1_CH2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integrating_o && cfg_mode_i == 2'd1) |-> chan_sel_o); // R3
  AST_TIMER_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (timer_o != '0)); // R6
  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(timer_o))); // R9
  AST_RESERVED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!integrating_o && mode_i == 2'd2) |=> !integrating_o); // R10
  AST_ABORT_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integrating_o && !enable_i) |=> (!done_o && !integrating_o)); // R11
endmodule

bind integ_seq integ_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .mode_i(mode_i),
  .chan_sel_o(chan_sel_o), .integrating_o(integrating_o), .result_o(result_o),
  .timer_o(timer_o), .done_o(done_o), .cfg_mode_i(cfg.mode)
);

// File: tb/tb_integ_seq.sv
module tb_integ_seq;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ext = 1'b0, sync = 1'b0, pulse = 1'b0;
  logic [1:0] mode = 2'd0, res = 2'd0;
  logic chan, integ, done;
  logic [15:0] result, timer;
  int n_chk = 0, n_fail = 0;

  integ_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .mode_i(mode), .ext_i(ext),
    .res_sel_i(res), .sync_i(sync), .pulse_i(pulse), .chan_sel_o(chan),
    .integrating_o(integ), .result_o(result), .timer_o(timer), .done_o(done)
  );

  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat16(int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  function automatic int exp_result(int m, int a0, int a1);
    if (m == 0) return a0;
    if (m == 1) return a1;
    return (a0 > a1) ? a0 - a1 : 0;
  endfunction

  function automatic int win_len(int r);
    return sat16(1 << (4 * (r + 1)));
  endfunction

  // drive one configuration until nwin results are checked
  task automatic run_cfg(int m, bit e, int r, int nwin, int pct0, int pct1, int smin, int smax);
    int acc0 = 0, acc1 = 0, len0 = 0, len1 = 0, got = 0, guard = 0, sp = 2;
    @(negedge clk);
    mode = 2'(m); ext = e; res = 2'(r); en = 1'b1;
    while (got < nwin && guard < 140000) begin
      @(negedge clk);
      guard++;
      if (done) begin
        int er, el;
        string tg;
        er = exp_result(m, acc0, acc1);
        el = (m == 0) ? len0 : len1;
        tg = (m == 0) ? "R2" : (m == 1) ? "R3" : (acc1 > acc0) ? "R5" : "R4";
        if (er == 65535) tg = "R8";
        chk(int'(result) == er, tg, "result", int'(result), er);
        chk(int'(timer) == el, e ? "R7" : "R6", "timer vs window", int'(timer), el);
        if (!e) chk(int'(timer) == win_len(r), "R6", "internal length", int'(timer), win_len(r));
        chk(integ == 1'b1, "R12", "restart", int'(integ), 1);
        acc0 = 0; acc1 = 0; len0 = 0; len1 = 0;
        got++;
      end
      pulse = (($urandom % 100) < (chan ? pct1 : pct0));
      if (integ) begin
        if (!chan) begin acc0 = sat16(acc0 + int'(pulse)); len0 = sat16(len0 + 1); end
        else       begin acc1 = sat16(acc1 + int'(pulse)); len1 = sat16(len1 + 1); end
      end
      if (e) begin
        sync = 1'b0;
        sp--;
        if (sp <= 0) begin
          sync = 1'b1;
          sp = smin + int'($urandom % (smax - smin + 1));
        end
      end
    end
    chk(got == nwin, "R9", "results seen", got, nwin);
    pulse = 1'b0; sync = 1'b0; en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] r_hold, t_hold;
    int bad;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(result == 16'd0 && timer == 16'd0, "R1", "reset outputs", int'(result) + int'(timer), 0);
    chk(!done && !integ, "R1", "reset flags", int'(done) + int'(integ), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cfg(0, 0, 0, 3, 50, 50, 1, 1);       // R2 R6
    run_cfg(1, 0, 1, 2, 30, 70, 1, 1);       // R3
    run_cfg(3, 0, 0, 3, 80, 20, 1, 1);       // R4
    run_cfg(3, 0, 0, 2, 10, 90, 1, 1);       // R5 clamp
    run_cfg(0, 1, 0, 4, 50, 50, 1, 3);       // R7 tight syncs
    run_cfg(3, 1, 0, 3, 60, 30, 5, 40);      // R4 R7
    run_cfg(0, 0, 2, 1, 40, 40, 1, 1);       // R6 12-bit
    run_cfg(0, 0, 3, 1, 100, 100, 1, 1);     // R8 saturation

    for (int i = 0; i < 6; i++) begin
      int m;
      m = (i % 3 == 2) ? 3 : (i % 3);
      run_cfg(m, 1'($urandom % 2), int'($urandom % 2), 2,
              int'($urandom % 101), int'($urandom % 101), 1, 30);
    end

    // R10 reserved mode stays idle
    r_hold = result; t_hold = timer; bad = 0;
    mode = 2'd2; ext = 1'b0; en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      pulse = 1'b1;
      if (integ || done) bad++;
    end
    chk(bad == 0, "R10", "activity in reserved mode", bad, 0);
    chk(result == r_hold && timer == t_hold, "R10", "outputs changed", int'(result), int'(r_hold));
    en = 1'b0; pulse = 1'b0;
    repeat (2) @(negedge clk);

    // R11 abort mid-window
    r_hold = result; t_hold = timer; bad = 0;
    mode = 2'd0; res = 2'd1; en = 1'b1;
    repeat (60) begin @(negedge clk); pulse = ~pulse; end
    chk(integ == 1'b1, "R11", "window open before abort", int'(integ), 1);
    en = 1'b0;
    @(negedge clk);
    chk(integ == 1'b0, "R11", "window closed after abort", int'(integ), 0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) bad++;
    end
    chk(bad == 0, "R11", "done after abort", bad, 0);
    chk(result == r_hold && timer == t_hold, "R11", "outputs changed", int'(timer), int'(t_hold));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule